// File: doc/BRIEF.md
# PCI Interrupt Line to ISA IRQ Router

The block steers four active-low PCI interrupt lines (INTA to INTD, numbered here as lines 1 to 4) onto a 16-line active-high ISA IRQ vector. Each line has a 4-bit routing code. The codes for lines 1 and 2 sit in one configuration byte and those for lines 3 and 4 in a second byte. The code picks a target IRQ from a sparse, non-linear table. Some codes are reserved and some disable the line. A third configuration byte holds one sensitivity bit per line. That bit decides whether the ISA side sees the interrupt as a level held for as long as the PCI line is asserted, or as a single one-clock pulse when the line first asserts.

The PCI inputs are asynchronous. They pass through a two-flop synchroniser before edge detection. When several lines land on the same IRQ, their contributions are ORed. The output vector is registered. The configuration bytes come from a register file outside the block and are taken as plain static inputs.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `irq_o` is all zeros.
- R2: IRQ bits 0, 1, 2, 8 and 13 are never driven by any routing code.
- R3: Line 1 takes its code from `route_lo_i[3:0]` and line 2 from `route_lo_i[7:4]`. Line 3 takes its code from `route_hi_i[3:0]` and line 4 from `route_hi_i[7:4]`. Line n is input `intx_n_i[n-1]`, which is active low.
- R4: Codes 1, 2, 3, 4, 5, 6 and 7 drive IRQ 9, 3, 10, 4, 5, 7 and 6 respectively.
- R5: Codes 9, 11, 13 and 15 drive IRQ 11, 12, 14 and 15 respectively.
- R6: Code 0 (disabled) and the reserved codes 8, 10, 12 and 14 drive no IRQ.
- R7: Bit n-1 of `sense_i` selects the mode of line n: 1 is edge mode and 0 is level mode.
- R8: In edge mode, each new assertion of a line gives exactly one high cycle on its IRQ. That cycle appears in the third clock after the input falls and stays for one clock, even while the line is held.
- R9: In level mode, the IRQ is high for as long as the line is asserted. It follows the input with a delay of three clocks.
- R10: Bits 7:4 of `sense_i` have no effect.
- R11: When several lines map to the same IRQ, that IRQ is the OR of their contributions.
- R12: A change of a routing code or sensitivity bit reaches `irq_o` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| route_lo_i | input | 8 | Routing codes for lines 1 (low nibble) and 2 (high nibble) |
| route_hi_i | input | 8 | Routing codes for lines 3 (low nibble) and 4 (high nibble) |
| sense_i | input | 8 | Per-line mode bits in 3:0, 1 = edge and 0 = level |
| intx_n_i | input | 4 | PCI interrupt lines, active low, asynchronous |
| irq_o | output | 16 | ISA IRQ vector, active high, registered |

## Verification
A change on a PCI line shows at `irq_o` three clock edges later: two synchroniser flops and then the output register. An edge-mode pulse is visible in exactly that one cycle. A change of configuration appears after a single edge, because it feeds the output register directly. The reference model in the bench steps on every rising edge with a synchroniser chain of its own. It compares 1 ns after the edge, while the stimulus only changes on falling edges. The directed checks wait the matching number of falling edges before they sample: three for line changes and one for configuration changes.

// File: rtl/irq_rt_pkg.sv
package irq_rt_pkg;
  localparam int NUM_LINES = 4;
  localparam int CODE_W    = 4;
  localparam int NUM_IRQ   = 16;

  typedef logic [CODE_W-1:0]  route_code_t;
  typedef logic [NUM_IRQ-1:0] irq_vec_t;

  // Sparse code table: returns a one-hot IRQ vector, or zero for off/reserved.
  function automatic irq_vec_t code_to_irq(route_code_t code);
    irq_vec_t v;
    v = '0;
    unique case (code)
      4'd1:  v[9]  = 1'b1;
      4'd2:  v[3]  = 1'b1;
      4'd3:  v[10] = 1'b1;
      4'd4:  v[4]  = 1'b1;
      4'd5:  v[5]  = 1'b1;
      4'd6:  v[7]  = 1'b1;
      4'd7:  v[6]  = 1'b1;
      4'd9:  v[11] = 1'b1;
      4'd11: v[12] = 1'b1;
      4'd13: v[14] = 1'b1;
      4'd15: v[15] = 1'b1;
      default: v = '0;
    endcase
    return v;
  endfunction

  // Pick the nibble for a line from the packed routing bytes.
  function automatic route_code_t pick_code(logic [15:0] bytes, int line);
    return route_code_t'(bytes >> (line * CODE_W));
  endfunction
endpackage

// File: rtl/irq_rt_sync.sv
module irq_rt_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] stage_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[s] <= '0;
        else         stage_q[s] <= stage_q[s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

  // R9: the last stage always carries what the previous stage held one clock earlier
  a_r9_sync_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stage_q[STAGES-1] == $past(stage_q[STAGES-2]));
endmodule

// File: rtl/irq_rt_lane.sv
module irq_rt_lane
  import irq_rt_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  route_code_t code_i,
  input  logic        edge_mode_i,
  input  logic        active_i,
  output irq_vec_t    contrib_o
);
  logic active_prev_q;
  logic rise_pulse;
  logic lane_drive;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) active_prev_q <= 1'b0;
    else         active_prev_q <= active_i;

  assign rise_pulse = active_i & ~active_prev_q;
  assign lane_drive = edge_mode_i ? rise_pulse : active_i;
  assign contrib_o  = lane_drive ? code_to_irq(code_i) : '0;

  // R8: a rising-edge pulse never lasts two consecutive cycles
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_pulse |=> !rise_pulse);

  // R2: no lane ever contributes to an unreachable IRQ
  a_r2_lane_unreached: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (contrib_o[0] | contrib_o[1] | contrib_o[2] | contrib_o[8] | contrib_o[13]) == 1'b0);
endmodule

// File: rtl/pci_irq_router.sv
module pci_irq_router
  import irq_rt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [7:0]  route_lo_i,
  input  logic [7:0]  route_hi_i,
  input  logic [7:0]  sense_i,
  input  logic [3:0]  intx_n_i,
  output logic [15:0] irq_o
);
  localparam int ROUTE_W = NUM_LINES * CODE_W;

  logic [NUM_LINES-1:0] line_active;
  logic [ROUTE_W-1:0]   route_bytes;
  irq_vec_t             lane_contrib [NUM_LINES];
  irq_vec_t             irq_next;
  irq_vec_t             irq_q;

  assign route_bytes = {route_hi_i, route_lo_i};

  irq_rt_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (~intx_n_i),
    .q_o    (line_active)
  );

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_lane
    irq_rt_lane u_lane (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .code_i      (pick_code(route_bytes, l)),
      .edge_mode_i (sense_i[l]),
      .active_i    (line_active[l]),
      .contrib_o   (lane_contrib[l])
    );
  end

  always_comb begin
    irq_next = '0;
    for (int l = 0; l < NUM_LINES; l++) irq_next |= lane_contrib[l];
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= '0;
    else         irq_q <= irq_next;

  assign irq_o = irq_q;

  // R2: unreachable IRQ lines stay low at the port
  a_r2_unreached_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o[0] | irq_o[1] | irq_o[2] | irq_o[8] | irq_o[13]) == 1'b0);

  // R11: at most one IRQ per line can be high
  a_r11_max_lines: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(irq_o) <= NUM_LINES);

  // R12: the output register holds what the lanes offered one clock before
  a_r12_one_clock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ##1 irq_o == $past(irq_next));
endmodule

// File: tb/tb_pci_irq_router.sv
`timescale 1ns/1ps
module tb_pci_irq_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  route_lo = 8'h00, route_hi = 8'h00, sense = 8'h00;
  logic [3:0]  intx_n = 4'hF;
  logic [15:0] irq;

  int n_cmp = 0, n_bad = 0, cycles = 0;
  string cur_req = "R1";

  pci_irq_router dut (
    .clk_i(clk), .rst_ni(rst_n), .route_lo_i(route_lo), .route_hi_i(route_hi),
    .sense_i(sense), .intx_n_i(intx_n), .irq_o(irq)
  );

  always #2.5 clk = ~clk;

  // Target IRQ per routing code; -1 means nothing driven.
  int tgt [16] = '{-1, 9, 3, 10, 4, 5, 7, 6, -1, 11, -1, 12, -1, 14, -1, 15};

  bit m_s1 [4], m_s2 [4], m_prev [4];
  logic [15:0] m_irq = 16'h0;

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int line_code(int ln);
    logic [7:0] b;
    b = (ln < 2) ? route_lo : route_hi;
    return (ln % 2 == 0) ? int'(b[3:0]) : int'(b[7:4]);
  endfunction

  // Behavioural reference, stepped on every rising edge.
  always @(posedge clk) begin
    logic [15:0] nxt;
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin m_s1[i] = 0; m_s2[i] = 0; m_prev[i] = 0; end
      m_irq = 16'h0;
    end else begin
      nxt = 16'h0;
      for (int i = 0; i < 4; i++) begin
        bit on;
        on = sense[i] ? (m_s2[i] && !m_prev[i]) : m_s2[i];
        if (on && tgt[line_code(i)] >= 0) nxt[tgt[line_code(i)]] = 1'b1;
      end
      m_irq = nxt;
      for (int i = 0; i < 4; i++) begin
        m_prev[i] = m_s2[i]; m_s2[i] = m_s1[i]; m_s1[i] = !intx_n[i];
      end
    end
    #1;
    check(cur_req, irq, m_irq);
    check("R2", irq & 16'h2107, 16'h0);
  end

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    while (cycles < 100000) begin @(posedge clk); cycles++; end
    n_bad++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int pulses;
    cyc(3);
    check("R1", irq, 16'h0);
    rst_n = 1'b1;
    cyc(1);
    check("R1", irq, 16'h0);

    // R4 R5 R6: every code on line 1, level mode
    for (int c = 0; c < 16; c++) begin
      cur_req = (c == 0 || (c >= 8 && c % 2 == 0)) ? "R6" : (c < 8 ? "R4" : "R5");
      route_lo = 8'(c); sense = 8'h00; intx_n = 4'b1110;
      cyc(3);
      check(cur_req, irq, tgt[c] < 0 ? 16'h0 : (16'h1 << tgt[c]));
      intx_n = 4'hF;
      cyc(3);
      check(cur_req, irq, 16'h0);
    end

    // R3: nibble positions for each line
    cur_req = "R3";
    route_lo = 8'h21; route_hi = 8'h54;
    intx_n = 4'b1101; cyc(3); check("R3", irq, 16'h1 << 3);
    intx_n = 4'b1011; cyc(3); check("R3", irq, 16'h1 << 4);
    intx_n = 4'b0111; cyc(3); check("R3", irq, 16'h1 << 5);
    intx_n = 4'hF; cyc(4);

    // R9: level held and released
    cur_req = "R9";
    route_lo = 8'h0F; intx_n = 4'b1110;
    cyc(2); check("R9", irq, 16'h0);
    cyc(1); check("R9", irq, 16'h8000);
    cyc(8); check("R9", irq, 16'h8000);
    intx_n = 4'hF; cyc(3); check("R9", irq, 16'h0);

    // R8 R7: edge mode gives one pulse while held
    cur_req = "R8";
    sense = 8'h01; intx_n = 4'b1110; pulses = 0;
    cyc(2);
    for (int i = 0; i < 10; i++) begin cyc(1); if (irq[15]) pulses++; end
    check("R8", 16'(pulses), 16'd1);
    check("R7", irq, 16'h0);
    intx_n = 4'hF; cyc(3);
    intx_n = 4'b1110; cyc(3); check("R8", irq, 16'h8000);
    cyc(1); check("R8", irq, 16'h0);
    intx_n = 4'hF; cyc(4);

    // R10: high sense bits do not select edge mode
    cur_req = "R10";
    sense = 8'hF0; route_hi = 8'h00; intx_n = 4'b1110;
    cyc(8); check("R10", irq, 16'h8000);
    intx_n = 4'hF; cyc(4);

    // R11: two lines on one IRQ are ORed
    cur_req = "R11";
    sense = 8'h00; route_lo = 8'h55; intx_n = 4'b1100;
    cyc(4); check("R11", irq, 16'h0020);
    intx_n = 4'b1101; cyc(4); check("R11", irq, 16'h0020);
    intx_n = 4'b1111; cyc(4); check("R11", irq, 16'h0);

    // R12: configuration change seen one clock later
    cur_req = "R12";
    route_lo = 8'h01; intx_n = 4'b1110; cyc(5);
    check("R12", irq, 16'h0200);
    route_lo = 8'h03; cyc(1); check("R12", irq, 16'h0400);
    sense = 8'h01; cyc(1); check("R12", irq, 16'h0);
    intx_n = 4'hF; cyc(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule